// File: doc/BRIEF.md
# USB Device Control-Endpoint Status and Address Register

This block is the status and control register that firmware uses to follow transactions on the control endpoint of a full-speed USB device. The protocol engine reports decoded token events as single-cycle strobes. The block turns them into flags that firmware can read. Some flags are set by hardware and cleared by firmware. The OUT flag is also cleared by hardware when a new SETUP token arrives. The IN flag only follows the most recent token.

The block also holds the device address. Firmware loads a new address through a dedicated write strobe. When the auto-address bit is 0, the address takes effect at once. When the bit is 1, the new address is held back until the host has acknowledged the IN data that follows the write. This lets the status stage of an address-setting request finish at the old address.

A global NAK mask decides whether each NAK the engine sends raises the interrupt request. The mask covers every endpoint.

Top module: `usb_sie_status`

## Requirements
- R1: After reset, the register read value is 0x00, the device address is 0 and the interrupt request is 0.
- R2: With bit 0 (auto-address) at 0, a write on the address port sets the device address to the written value on the next clock edge.
- R3: With bit 0 at 1, an address write is held. The device address takes the most recently written value one cycle after the first IN-acknowledge strobe in a cycle later than that write. An acknowledge in the same cycle as the write does not count, and an acknowledge with nothing held leaves the address unchanged.
- R4: Bit 0 is read/write by firmware only. No token event changes it, SETUP included.
- R5: Bit 1 (FIFO error) is set by the FIFO-error strobe. A register write with 0 in bit 1 clears it, and a write with 1 in bit 1 leaves it as it is.
- R6: Bit 2 (OUT received) is set by the OUT strobe and not by the zero-length OUT strobe. It is cleared by a register write with 0 in bit 2, or by the SETUP strobe.
- R7: Bit 3 (IN token) is read-only. It is 1 after an IN strobe and stays 1 until a SETUP, OUT or zero-length OUT strobe.
- R8: Bit 4 (no response) is set by the no-response strobe and is cleared by a register write with 0 in bit 4.
- R9: Bit 5 (packet fault) is set by the CRC/PID/bit-stuff error strobe and is cleared by a register write with 0 in bit 5.
- R10: Bit 6 (NAK mask) is read/write. The interrupt request is 1 in the cycle after a NAK-sent strobe when bit 6 was 0, and is 0 at every other time.
- R11: Bit 7 always reads 0, whatever is written to it.
- R12: When a hardware set of a flag falls in the same cycle as a clear of that flag, by firmware or by SETUP, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evSetup | input | 1 | Valid SETUP token received |
| evIn | input | 1 | IN token received |
| evOut | input | 1 | OUT token with data received |
| evOutZero | input | 1 | Zero-length OUT received |
| evInAck | input | 1 | Host acknowledged IN data |
| evCrcErr | input | 1 | CRC, PID or bit-stuff error |
| evFifoErr | input | 1 | FIFO access error on any endpoint |
| evNoResp | input | 1 | Token left without any handshake or data |
| evNakSent | input | 1 | Engine sent a NAK |
| regWrEn | input | 1 | Firmware write to the status register |
| regWrData | input | 8 | Status register write data |
| addrWrEn | input | 1 | Firmware write to the address register |
| addrWrData | input | ADDR_W | New device address |
| regRdData | output | 8 | Status register read value |
| devAddr | output | ADDR_W | Active device address |
| irq | output | 1 | NAK interrupt request |

## Verification
Every result is registered. A strobe or write that is sampled at a rising edge shows on `regRdData`, `devAddr` or `irq` right after that edge, so it is due one cycle later. A deferred address is due one cycle after the acknowledge that releases it, not after the address write. The bench drives inputs at falling edges and updates its own model at the next rising edge. It compares all outputs at the falling edge that follows, which is exactly one cycle after the stimulus. This timing applies to the random traffic and to the directed same-cycle collision cases alike.

// File: rtl/sie_stat_pkg.sv
package sie_stat_pkg;
  localparam int REG_W      = 8;
  localparam int NUM_STICKY = 4;   // err, out, noResp, crc

  localparam int POS_AUTO   = 0;
  localparam int POS_ERR    = 1;
  localparam int POS_OUT    = 2;
  localparam int POS_IN     = 3;
  localparam int POS_NORESP = 4;
  localparam int POS_CRC    = 5;
  localparam int POS_NAKMSK = 6;

  // sticky index -> register bit position
  function automatic int stickyPos(input int idx);
    case (idx)
      0:       return POS_ERR;
      1:       return POS_OUT;
      2:       return POS_NORESP;
      default: return POS_CRC;
    endcase
  endfunction

  typedef struct packed {
    logic                  fwRegWr;
    logic [NUM_STICKY-1:0] stickySet;
    logic [NUM_STICKY-1:0] stickyHwClr;
    logic                  inSet;
    logic                  inClr;
    logic                  addrLoadNow;
    logic                  addrHold;
    logic                  addrFire;
    logic                  nakPulse;
  } sie_strobe_t;
endpackage

// File: rtl/sie_stat_ctrl.sv
module sie_stat_ctrl
  import sie_stat_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        evSetup,
  input  logic        evIn,
  input  logic        evOut,
  input  logic        evOutZero,
  input  logic        evInAck,
  input  logic        evCrcErr,
  input  logic        evFifoErr,
  input  logic        evNoResp,
  input  logic        evNakSent,
  input  logic        regWrEn,
  input  logic        addrWrEn,
  input  logic        autoAddrBit,
  input  logic        nakMaskBit,
  output sie_strobe_t stb
);
  logic pendingQ;

  always_comb begin
    stb             = '0;
    stb.fwRegWr     = regWrEn;
    stb.stickySet   = {evCrcErr, evNoResp, evOut, evFifoErr};
    stb.stickyHwClr = {1'b0, 1'b0, evSetup, 1'b0};
    stb.inSet       = evIn;
    stb.inClr       = evSetup | evOut | evOutZero;
    stb.addrLoadNow = addrWrEn & ~autoAddrBit;
    stb.addrHold    = addrWrEn;
    // an acknowledge in the arming cycle belongs to an earlier transfer
    stb.addrFire    = evInAck & pendingQ & ~addrWrEn;
    stb.nakPulse    = evNakSent & ~nakMaskBit;
  end

  always_ff @(posedge clk) begin
    if (rst)                 pendingQ <= 1'b0;
    else if (addrWrEn)       pendingQ <= autoAddrBit;
    else if (stb.addrFire)   pendingQ <= 1'b0;
  end
endmodule

// File: rtl/sie_stat_dp.sv
module sie_stat_dp
  import sie_stat_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  sie_strobe_t       stb,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [ADDR_W-1:0] addrWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic [ADDR_W-1:0] devAddr,
  output logic              irq,
  output logic              autoAddrBit,
  output logic              nakMaskBit
);
  logic [NUM_STICKY-1:0] stickyQ;
  logic                  inQ;
  logic [ADDR_W-1:0]     addrHoldQ;
  logic [ADDR_W-1:0]     devAddrQ;
  logic                  irqQ;
  logic                  autoQ;
  logic                  nakMskQ;

  // hardware set outranks every clear
  for (genvar gi = 0; gi < NUM_STICKY; gi++) begin : g_sticky
    localparam int BitPos = stickyPos(gi);
    logic fwClr;
    assign fwClr = stb.fwRegWr & ~regWrData[BitPos];
    always_ff @(posedge clk) begin
      if (rst) stickyQ[gi] <= 1'b0;
      else     stickyQ[gi] <= stb.stickySet[gi] |
                              (stickyQ[gi] & ~fwClr & ~stb.stickyHwClr[gi]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inQ       <= 1'b0;
      autoQ     <= 1'b0;
      nakMskQ   <= 1'b0;
      irqQ      <= 1'b0;
      addrHoldQ <= '0;
      devAddrQ  <= '0;
    end else begin
      inQ  <= stb.inSet | (inQ & ~stb.inClr);
      irqQ <= stb.nakPulse;
      if (stb.fwRegWr) begin
        autoQ   <= regWrData[POS_AUTO];
        nakMskQ <= regWrData[POS_NAKMSK];
      end
      if (stb.addrHold)   addrHoldQ <= addrWrData;
      if (stb.addrLoadNow)   devAddrQ <= addrWrData;
      else if (stb.addrFire) devAddrQ <= addrHoldQ;
    end
  end

  always_comb begin
    regRdData             = '0;
    regRdData[POS_AUTO]   = autoQ;
    regRdData[POS_IN]     = inQ;
    regRdData[POS_NAKMSK] = nakMskQ;
    for (int i = 0; i < NUM_STICKY; i++)
      regRdData[stickyPos(i)] = stickyQ[i];
  end

  assign devAddr     = devAddrQ;
  assign irq         = irqQ;
  assign autoAddrBit = autoQ;
  assign nakMaskBit  = nakMskQ;
endmodule

// File: rtl/usb_sie_status.sv
module usb_sie_status
  import sie_stat_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evSetup,
  input  logic              evIn,
  input  logic              evOut,
  input  logic              evOutZero,
  input  logic              evInAck,
  input  logic              evCrcErr,
  input  logic              evFifoErr,
  input  logic              evNoResp,
  input  logic              evNakSent,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  input  logic              addrWrEn,
  input  logic [ADDR_W-1:0] addrWrData,
  output logic [7:0]        regRdData,
  output logic [ADDR_W-1:0] devAddr,
  output logic              irq
);
  sie_strobe_t stb;
  logic        autoAddrBit;
  logic        nakMaskBit;

  sie_stat_ctrl ctrl_i (
    .clk(clk), .rst(rst),
    .evSetup(evSetup), .evIn(evIn), .evOut(evOut), .evOutZero(evOutZero),
    .evInAck(evInAck), .evCrcErr(evCrcErr), .evFifoErr(evFifoErr),
    .evNoResp(evNoResp), .evNakSent(evNakSent),
    .regWrEn(regWrEn), .addrWrEn(addrWrEn),
    .autoAddrBit(autoAddrBit), .nakMaskBit(nakMaskBit),
    .stb(stb)
  );

  sie_stat_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rst(rst), .stb(stb),
    .regWrData(regWrData), .addrWrData(addrWrData),
    .regRdData(regRdData), .devAddr(devAddr), .irq(irq),
    .autoAddrBit(autoAddrBit), .nakMaskBit(nakMaskBit)
  );
endmodule

// File: rtl/sie_stat_chk.sv
module sie_stat_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              evSetup,
  input logic              evIn,
  input logic              evOut,
  input logic              evOutZero,
  input logic              evInAck,
  input logic              evCrcErr,
  input logic              evFifoErr,
  input logic              evNoResp,
  input logic              evNakSent,
  input logic              regWrEn,
  input logic [7:0]        regWrData,
  input logic              addrWrEn,
  input logic [ADDR_W-1:0] addrWrData,
  input logic [7:0]        regRdData,
  input logic [ADDR_W-1:0] devAddr,
  input logic              irq
);
  // R10
  nak_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (evNakSent && !regRdData[6]) |=> irq);

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!evNakSent || regRdData[6]) |=> !irq);

  // R2
  addr_now_chk: assert property (@(posedge clk) disable iff (rst)
    (addrWrEn && !regRdData[0]) |=> (devAddr == $past(addrWrData)));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!addrWrEn && !evInAck) |=> $stable(devAddr));

  // R12
  err_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    evFifoErr |=> regRdData[1]);

  // R9
  crc_set_chk: assert property (@(posedge clk) disable iff (rst)
    evCrcErr |=> regRdData[5]);

  // R6
  out_setup_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (evSetup && !evOut) |=> !regRdData[2]);

  // R11
  top_bit_zero_chk: assert property (@(posedge clk) disable iff (rst)
    regRdData[7] == 1'b0);
endmodule

bind usb_sie_status sie_stat_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/usb_sie_status_tb.sv
`timescale 1ns/1ps
module usb_sie_status_tb_top;
  localparam int AW = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst;
  logic evSetup, evIn, evOut, evOutZero, evInAck, evCrcErr, evFifoErr, evNoResp, evNakSent;
  logic regWrEn, addrWrEn;
  logic [7:0] regWrData, regRdData;
  logic [AW-1:0] addrWrData, devAddr;
  logic irq;

  usb_sie_status #(.ADDR_W(AW)) dut_i (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic mAuto, mErr, mOut, mIn, mNoResp, mCrc, mNak, mPend, mIrq;
  logic [AW-1:0] mHold, mDev;

  function automatic logic [7:0] expReg();
    return {1'b0, mNak, mCrc, mNoResp, mIn, mOut, mErr, mAuto};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    {mAuto, mErr, mOut, mIn, mNoResp, mCrc, mNak, mPend, mIrq} = '0;
    mHold = '0; mDev = '0;
  endtask

  task automatic modelStep();
    logic fw;
    logic oldAuto, oldNak;
    fw = regWrEn; oldAuto = mAuto; oldNak = mNak;
    mErr    = evFifoErr | (mErr    & ~(fw & ~regWrData[1]));
    mOut    = evOut     | (mOut    & ~(fw & ~regWrData[2]) & ~evSetup);
    mNoResp = evNoResp  | (mNoResp & ~(fw & ~regWrData[4]));
    mCrc    = evCrcErr  | (mCrc    & ~(fw & ~regWrData[5]));
    mIn     = evIn      | (mIn     & ~(evSetup | evOut | evOutZero));
    mIrq    = evNakSent & ~oldNak;
    if (fw) begin mAuto = regWrData[0]; mNak = regWrData[6]; end
    if (addrWrEn) begin
      mHold = addrWrData;
      if (!oldAuto) begin mDev = addrWrData; mPend = 1'b0; end
      else mPend = 1'b1;
    end else if (evInAck && mPend) begin
      mDev = mHold; mPend = 1'b0;
    end
  endtask

  task automatic idleIn();
    {evSetup, evIn, evOut, evOutZero, evInAck, evCrcErr, evFifoErr, evNoResp, evNakSent} = '0;
    regWrEn = 0; regWrData = '0; addrWrEn = 0; addrWrData = '0;
  endtask

  task automatic checkAll();
    logic [7:0] e;
    e = expReg();
    chk("R4 auto bit",   regRdData[0], e[0]);
    chk("R5 err bit",    regRdData[1], e[1]);
    chk("R6 out bit",    regRdData[2], e[2]);
    chk("R7 in bit",     regRdData[3], e[3]);
    chk("R8 noresp bit", regRdData[4], e[4]);
    chk("R9 crc bit",    regRdData[5], e[5]);
    chk("R10 mask bit",  regRdData[6], e[6]);
    chk("R11 bit7",      regRdData[7], 1'b0);
    chk("R2/R3 devAddr", devAddr, mDev);
    chk("R10 irq",       irq, mIrq);
  endtask

  // inputs already driven at a falling edge
  task automatic step();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    checkAll();
    idleIn();
  endtask

  task automatic randIn();
    evSetup   = ($urandom % 10) == 0;
    evIn      = ($urandom % 6)  == 0;
    evOut     = ($urandom % 6)  == 0;
    evOutZero = ($urandom % 10) == 0;
    evInAck   = ($urandom % 5)  == 0;
    evCrcErr  = ($urandom % 12) == 0;
    evFifoErr = ($urandom % 12) == 0;
    evNoResp  = ($urandom % 12) == 0;
    evNakSent = ($urandom % 4)  == 0;
    regWrEn   = ($urandom % 7)  == 0;
    regWrData = 8'($urandom);
    addrWrEn  = ($urandom % 9)  == 0;
    addrWrData = AW'($urandom);
  endtask

  initial begin
    void'($urandom(32'h5EED_0017));
    idleIn();
    rst = 1'b1;
    modelReset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 reg after reset",  regRdData, 8'h00);
    chk("R1 addr after reset", devAddr, '0);
    chk("R1 irq after reset",  irq, 1'b0);

    // R2 immediate address
    addrWrEn = 1; addrWrData = 7'h15; step();
    chk("R2 immediate addr", devAddr, 7'h15);

    // R3 deferred address
    regWrEn = 1; regWrData = 8'h01; step();
    addrWrEn = 1; addrWrData = 7'h2A; step();
    chk("R3 held before ack", devAddr, 7'h15);
    evSetup = 1; step();
    chk("R4 setup keeps auto", regRdData[0], 1'b1);
    addrWrEn = 1; addrWrData = 7'h33; evInAck = 1; step();
    chk("R3 same-cycle ack ignored", devAddr, 7'h15);
    evInAck = 1; step();
    chk("R3 ack releases latest", devAddr, 7'h33);
    evInAck = 1; step();
    chk("R3 idle ack no change", devAddr, 7'h33);

    // R12 set beats clear
    evFifoErr = 1; step();
    evFifoErr = 1; regWrEn = 1; regWrData = 8'h00; step();
    chk("R12 err set vs fw clear", regRdData[1], 1'b1);
    evOut = 1; evSetup = 1; step();
    chk("R12 out set vs setup", regRdData[2], 1'b1);
    evOutZero = 1; step();
    chk("R7 zlp clears in", regRdData[3], 1'b0);

    // R11 / R5 write-one has no effect on sticky
    regWrEn = 1; regWrData = 8'hFF; step();
    chk("R11 bit7 write ignored", regRdData[7], 1'b0);
    chk("R5 write one keeps err", regRdData[1], 1'b1);

    // R10 mask on: no irq
    evNakSent = 1; step();
    chk("R10 masked nak", irq, 1'b0);
    regWrEn = 1; regWrData = 8'h00; step();
    evNakSent = 1; step();
    chk("R10 unmasked nak", irq, 1'b1);

    for (int n = 0; n < 4000; n++) begin
      randIn();
      step();
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule